// File: doc/BRIEF.md
# Parallel Display Bus Cycle Engine

This block is the host-side engine that carries out one transfer on an asynchronous parallel character-display bus of the 6800 kind. The bus has a register-select line, a read/write line, an enable strobe and eight data lines. A requester hands over a register select, a read flag and a write byte. The engine then places the select and direction on the bus and raises the strobe. On a write it drives the data lines; on a read it samples them. It releases everything again in an order that respects the bus's minimum timing. Each nanosecond limit (strobe cycle, strobe high width, control setup and hold, write-data setup, read-data delay) is a parameter. It is turned into a clock count at elaboration by rounding up against a clock-period parameter.

A request is taken only while the engine is idle (`req_ready` high). The narrow-bus flag is latched with it. In narrow mode the byte moves as two complete strobe cycles on data lines 7..4, the upper nibble first. A separating gap keeps the strobe rise-to-rise time legal between the two nibbles. When the last hold interval has elapsed, `done` pulses for one clock and `rd_data` holds the byte read. After that the engine stays busy for a recovery interval, so that the next request cannot shorten the strobe cycle.

The sequencer has the states IDLE, SETUP, STROBE, HOLD, GAP, DONE and RECOVER. IDLE goes to SETUP on an accepted request. SETUP goes to STROBE when its count runs out, and STROBE goes to HOLD when its count runs out. HOLD goes to GAP after the first nibble of a narrow transfer, and to DONE otherwise. GAP goes back to SETUP for the second nibble. DONE always goes to RECOVER, and RECOVER goes to IDLE when its count runs out.

Top module: `pbus_cycle_engine`

## Requirements
- R1: After reset the strobe is low, the direction line is high (read), the data drivers are off, `req_ready` is high, `done` is low and `rd_data` is 0.
- R2: A request is taken only on a clock where `req_valid` and `req_ready` are both high. `req_ready` is low from then until the recovery interval has ended, and request inputs seen while busy have no effect on the bus or on `rd_data`.
- R3: Each strobe pulse stays high for exactly HIGH_CYC clocks. HIGH_CYC is the largest of the rounded-up strobe width, read-data delay and write-data setup.
- R4: Select and direction are set up at least SETUP_CYC (at least 1) clocks before the strobe rises. They stay unchanged while it is high and for HOLD_CYC (at least 1) clocks after it falls.
- R5: On a write the data drivers are enabled and the data lines are unchanged from setup through hold. The drivers are never enabled while the direction line is high.
- R6: Successive strobe rises are at least CYC_CYC clocks apart, where CYC_CYC is the rounded-up strobe cycle time.
- R7: In wide mode (`req_narrow`=0) a request makes exactly one strobe pulse, and a write drives the whole byte on data lines 7..0.
- R8: In narrow mode (`req_narrow`=1) a request makes exactly two strobe pulses. A write drives bits 7..4 of the byte on data lines 7..4 in the first pulse and bits 3..0 there in the second, with lines 3..0 driven 0.
- R9: A read samples the data lines on the last clock of each strobe pulse. Wide mode returns all eight lines. Narrow mode returns lines 7..4 of the first pulse as bits 7..4 and lines 7..4 of the second as bits 3..0. `rd_data` changes only on reads.
- R10: `done` is high for exactly one clock, SETUP_CYC+HIGH_CYC+HOLD_CYC clocks after acceptance in wide mode. In narrow mode it comes 2*(SETUP_CYC+HIGH_CYC+HOLD_CYC)+GAP_CYC clocks after acceptance, with GAP_CYC = max(1, CYC_CYC-SETUP_CYC-HIGH_CYC-HOLD_CYC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_rs | input | 1 | Register select to place on the bus |
| req_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| req_narrow | input | 1 | 1 = byte moves as two nibbles on lines 7..4 |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Engine idle, request will be taken |
| done | output | 1 | One-clock pulse at the end of the transfer |
| rd_data | output | 8 | Byte from the most recent read |
| bus_rs | output | 1 | Bus register select |
| bus_rw | output | 1 | Bus direction, 1 = read |
| bus_e | output | 1 | Bus enable strobe |
| db_out | output | 8 | Data lines driven on writes |
| db_oe | output | 1 | Data line output enable |
| db_in | input | 8 | Data lines sampled on reads |

## Verification
The bench builds the engine with a 50 ns clock period and the default nanosecond limits. This gives a setup of 1 clock, a strobe of 3 clocks (the read-data delay rounds to 2), a hold of 1 clock, a strobe cycle of 24 clocks and a gap of 19 clocks. With counts this short, every write byte and every read byte can be swept in both bus widths and with both select values. On reads the bench drives junk on the data lines until the read-data delay has passed, so a sample taken too early is caught. Each transfer also keeps the request inputs toggling while the engine is busy.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_GAP,
        ST_DONE,
        ST_RECOVER
    } pbus_state_t;

    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbus_phase_fsm.sv
module pbus_phase_fsm
    import pbus_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int HIGH_CYC  = 7,
    parameter int HOLD_CYC  = 1,
    parameter int GAP_CYC   = 51,
    parameter int CYC_CYC   = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        two_phase,
    output pbus_state_t state_o,
    output logic        phase_o,
    output logic        strobe_last_o,
    output logic        e_o,
    output logic        done_o,
    output logic        ready_o
);

    localparam int MAX_CNT = max2(max2(SETUP_CYC, HIGH_CYC), max2(HOLD_CYC, GAP_CYC));
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam int GAP_W   = $clog2(CYC_CYC + 1);

    pbus_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             phase_q, phase_d;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
        phase_d = phase_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SETUP;
                    cnt_d   = CNT_W'(SETUP_CYC - 1);
                    phase_d = 1'b0;
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    state_d = ST_STROBE;
                    cnt_d   = CNT_W'(HIGH_CYC - 1);
                end
            end
            ST_STROBE: begin
                if (cnt_zero) begin
                    state_d = ST_HOLD;
                    cnt_d   = CNT_W'(HOLD_CYC - 1);
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    if (two_phase && !phase_q) begin
                        state_d = ST_GAP;
                        cnt_d   = CNT_W'(GAP_CYC - 1);
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_GAP: begin
                if (cnt_zero) begin
                    state_d = ST_SETUP;
                    cnt_d   = CNT_W'(SETUP_CYC - 1);
                    phase_d = 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_RECOVER;
                cnt_d   = CNT_W'(GAP_CYC - 1);
            end
            ST_RECOVER: begin
                if (cnt_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            phase_q <= phase_d;
        end
    end

    // outputs
    always_comb begin
        state_o       = state_q;
        phase_o       = phase_q;
        e_o           = (state_q == ST_STROBE);
        strobe_last_o = (state_q == ST_STROBE) && cnt_zero;
        done_o        = (state_q == ST_DONE);
        ready_o       = (state_q == ST_IDLE);
    end

    // checker counters: strobe width and rise-to-rise spacing
    logic [CNT_W-1:0] hi_run_q;
    logic [GAP_W-1:0] since_rise_q;
    logic             e_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q     <= '0;
            since_rise_q <= GAP_W'(CYC_CYC);
            e_q          <= 1'b0;
        end else begin
            e_q      <= e_o;
            hi_run_q <= e_o ? hi_run_q + 1'b1 : '0;
            if (e_o && !e_q)
                since_rise_q <= GAP_W'(1);
            else if (since_rise_q != GAP_W'(CYC_CYC))
                since_rise_q <= since_rise_q + 1'b1;
        end
    end

    assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!e_o && e_q) |-> (hi_run_q == CNT_W'(HIGH_CYC)));

    assert_rise_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (e_o && !e_q) |-> (since_rise_q == GAP_W'(CYC_CYC)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_no_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start) |=> !ready_o);

endmodule

// File: rtl/pbus_lane_mux.sv
module pbus_lane_mux
    import pbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_rs,
    input  logic              req_rd,
    input  logic              req_narrow,
    input  logic [DATA_W-1:0] req_wdata,
    input  pbus_state_t       state,
    input  logic              phase,
    input  logic              sample,
    input  logic [DATA_W-1:0] db_in,
    output logic              narrow_q,
    output logic              bus_rs,
    output logic              bus_rw,
    output logic [DATA_W-1:0] db_out,
    output logic              db_oe,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NIB_W = DATA_W / 2;

    logic              rs_q, rd_q;
    logic [DATA_W-1:0] wdata_q, rd_q_data;
    logic              drive_window;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q     <= 1'b0;
            rd_q     <= 1'b1;
            narrow_q <= 1'b0;
            wdata_q  <= '0;
        end else if (start) begin
            rs_q     <= req_rs;
            rd_q     <= req_rd;
            narrow_q <= req_narrow;
            wdata_q  <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q_data <= '0;
        end else if (sample && rd_q) begin
            if (!narrow_q)
                rd_q_data <= db_in;
            else if (!phase)
                rd_q_data[DATA_W-1:NIB_W] <= db_in[DATA_W-1:NIB_W];
            else
                rd_q_data[NIB_W-1:0] <= db_in[DATA_W-1:NIB_W];
        end
    end

    assign drive_window = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);

    always_comb begin
        bus_rs  = rs_q;
        bus_rw  = rd_q;
        db_oe   = !rd_q && drive_window;
        rd_data = rd_q_data;
        if (!narrow_q)
            db_out = wdata_q;
        else if (!phase)
            db_out = {wdata_q[DATA_W-1:NIB_W], {NIB_W{1'b0}}};
        else
            db_out = {wdata_q[NIB_W-1:0], {NIB_W{1'b0}}};
    end

    assert_oe_only_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        db_oe |-> !bus_rw);

    assert_wdata_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (db_oe && $past(db_oe)) |-> $stable(db_out));

    assert_rd_only_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rw |=> $stable(rd_data));

endmodule

// File: rtl/pbus_cycle_engine.sv
module pbus_cycle_engine
    import pbus_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_CYCLE_NS    = 1200,
    parameter int T_EHIGH_NS    = 140,
    parameter int T_CSETUP_NS   = 0,
    parameter int T_CHOLD_NS    = 10,
    parameter int T_WSETUP_NS   = 40,
    parameter int T_RDELAY_NS   = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_rs,
    input  logic       req_rd,
    input  logic       req_narrow,
    input  logic [7:0] req_wdata,
    output logic       req_ready,
    output logic       done,
    output logic [7:0] rd_data,
    output logic       bus_rs,
    output logic       bus_rw,
    output logic       bus_e,
    output logic [7:0] db_out,
    output logic       db_oe,
    input  logic [7:0] db_in
);

    localparam int DATA_W    = 8;
    localparam int SETUP_CYC = max2(1, ns_to_cyc(T_CSETUP_NS, CLK_PERIOD_NS));
    localparam int HIGH_CYC  = max2(1, max2(ns_to_cyc(T_EHIGH_NS, CLK_PERIOD_NS),
                                    max2(ns_to_cyc(T_RDELAY_NS, CLK_PERIOD_NS),
                                         ns_to_cyc(T_WSETUP_NS, CLK_PERIOD_NS))));
    localparam int HOLD_CYC  = max2(1, ns_to_cyc(T_CHOLD_NS, CLK_PERIOD_NS));
    localparam int CYC_CYC   = max2(ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS),
                                    SETUP_CYC + HIGH_CYC + HOLD_CYC + 1);
    localparam int GAP_CYC   = max2(1, CYC_CYC - SETUP_CYC - HIGH_CYC - HOLD_CYC);

    pbus_state_t state;
    logic        phase, sample, start, narrow_q;

    assign start = req_valid && req_ready;

    pbus_phase_fsm #(
        .SETUP_CYC (SETUP_CYC),
        .HIGH_CYC  (HIGH_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .GAP_CYC   (GAP_CYC),
        .CYC_CYC   (CYC_CYC)
    ) i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .two_phase     (narrow_q),
        .state_o       (state),
        .phase_o       (phase),
        .strobe_last_o (sample),
        .e_o           (bus_e),
        .done_o        (done),
        .ready_o       (req_ready)
    );

    pbus_lane_mux #(
        .DATA_W (DATA_W)
    ) i_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_rs     (req_rs),
        .req_rd     (req_rd),
        .req_narrow (req_narrow),
        .req_wdata  (req_wdata),
        .state      (state),
        .phase      (phase),
        .sample     (sample),
        .db_in      (db_in),
        .narrow_q   (narrow_q),
        .bus_rs     (bus_rs),
        .bus_rw     (bus_rw),
        .db_out     (db_out),
        .db_oe      (db_oe),
        .rd_data    (rd_data)
    );

    assert_ctrl_steady_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_e |-> ($stable(bus_rs) && $stable(bus_rw)));

    assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_e) |-> ($stable(bus_rs) && $stable(bus_rw)));

    assert_no_strobe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_e |-> !req_ready);

endmodule

// File: tb/test_pbus_cycle_engine.sv
module test_pbus_cycle_engine;

    localparam int CLK_NS  = 50;
    localparam int EXP_S   = 1;                        // setup, 0 ns -> min 1
    localparam int EXP_H   = (140 + CLK_NS - 1) / CLK_NS; // 3, dominates 100 and 40 ns
    localparam int EXP_HD  = (10 + CLK_NS - 1) / CLK_NS;  // 1
    localparam int EXP_CYC = (1200 + CLK_NS - 1) / CLK_NS; // 24
    localparam int EXP_GAP = EXP_CYC - EXP_S - EXP_H - EXP_HD; // 19
    localparam int EXP_DDR = (100 + CLK_NS - 1) / CLK_NS; // 2

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_rs = 1'b0, req_rd = 1'b0, req_narrow = 1'b0;
    logic [7:0] req_wdata = '0;
    logic       req_ready, done, bus_rs, bus_rw, bus_e, db_oe;
    logic [7:0] rd_data, db_out;
    logic [7:0] db_in = '0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_NS / 2) clk = ~clk;

    pbus_cycle_engine #(.CLK_PERIOD_NS(CLK_NS)) i_pbus_cycle_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rs(req_rs),
        .req_rd(req_rd), .req_narrow(req_narrow), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rd_data(rd_data), .bus_rs(bus_rs),
        .bus_rw(bus_rw), .bus_e(bus_e), .db_out(db_out), .db_oe(db_oe), .db_in(db_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bus monitor and read-data model
    logic       cur_nib = 1'b0;
    logic [7:0] cur_rv = '0;
    int         npulse = 0;
    int         hi_len = 0;
    int         since_rise = 1000;
    logic       p_e = 1'b0, p_rs = 1'b0, p_rw = 1'b1, p_oe = 1'b0;
    logic [7:0] p_db = '0;
    logic [7:0] pulse_db [2];
    logic       pulse_oe [2];
    logic       pulse_rs [2];
    logic       pulse_rw [2];

    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] good;
            since_rise++;
            check(!(db_oe && bus_rw), "R5 oe while read", int'(db_oe), 0);
            if (bus_e && !p_e) begin
                check(since_rise >= EXP_CYC, "R6 rise spacing", since_rise, EXP_CYC);
                check(bus_rs == p_rs && bus_rw == p_rw, "R4 setup", {bus_rs, bus_rw}, {p_rs, p_rw});
                check(db_oe == p_oe && (!db_oe || db_out == p_db), "R5 data setup", db_out, p_db);
                since_rise = 0;
                npulse++;
                hi_len = 0;
            end
            if (bus_e) begin
                hi_len++;
                if (p_e)
                    check(bus_rs == p_rs && bus_rw == p_rw && db_out == p_db,
                          "R4 steady strobe", {bus_rs, bus_rw, db_out}, {p_rs, p_rw, p_db});
            end
            if (!bus_e && p_e) begin
                check(hi_len == EXP_H, "R3 strobe width", hi_len, EXP_H);
                check(bus_rs == p_rs && bus_rw == p_rw, "R4 hold", {bus_rs, bus_rw}, {p_rs, p_rw});
                check(!p_oe || (db_oe && db_out == p_db), "R5 data hold", db_out, p_db);
                if (npulse >= 1 && npulse <= 2) begin
                    pulse_db[npulse-1] = p_db;
                    pulse_oe[npulse-1] = p_oe;
                    pulse_rs[npulse-1] = p_rs;
                    pulse_rw[npulse-1] = p_rw;
                end
            end
            if (!cur_nib) good = cur_rv;
            else if (npulse <= 1) good = {cur_rv[7:4], 4'h5};
            else good = {cur_rv[3:0], 4'hA};
            if (bus_e && hi_len >= EXP_DDR) db_in = good;
            else if (!(!bus_e && p_e)) db_in = ~good;
            p_e = bus_e; p_rs = bus_rs; p_rw = bus_rw; p_oe = db_oe; p_db = db_out;
        end
    end

    logic [7:0] last_rd = '0;

    task automatic xfer(input bit rs, input bit rd, input bit nib, input logic [7:0] wd,
                        input logic [7:0] rv);
        int n;
        int exp_n;
        @(negedge clk); #1;
        cur_rv = rv; cur_nib = nib; npulse = 0;
        pulse_db[0] = 'x; pulse_db[1] = 'x;
        req_valid = 1'b1; req_rs = rs; req_rd = rd; req_narrow = nib; req_wdata = wd;
        check(req_ready == 1'b1, "R2 ready before request", int'(req_ready), 1);
        @(posedge clk); #1;
        // toggle request inputs while busy (R2: no effect)
        req_rs = ~rs; req_rd = ~rd; req_narrow = ~nib; req_wdata = ~wd;
        n = 0;
        while (n < 200) begin
            @(negedge clk);
            n++;
            if (n == 4) begin #1; req_valid = 1'b0; end
            if (done) break;
        end
        exp_n = nib ? 2 * (EXP_S + EXP_H + EXP_HD) + EXP_GAP + 1 : EXP_S + EXP_H + EXP_HD + 1;
        check(n == exp_n, "R10 done latency", n, exp_n);
        check(npulse == (nib ? 2 : 1), nib ? "R8 pulse count" : "R7 pulse count", npulse, nib ? 2 : 1);
        for (int i = 0; i < (nib ? 2 : 1); i++) begin
            check(pulse_rs[i] == rs && pulse_rw[i] == rd, "R4 select/direction", {pulse_rs[i], pulse_rw[i]}, {rs, rd});
            if (rd) begin
                check(pulse_oe[i] == 1'b0, "R5 no drive on read", int'(pulse_oe[i]), 0);
            end else if (!nib) begin
                check(pulse_oe[i] && pulse_db[i] == wd, "R7 wide write data", pulse_db[i], wd);
            end else begin
                logic [7:0] e8;
                e8 = (i == 0) ? {wd[7:4], 4'h0} : {wd[3:0], 4'h0};
                check(pulse_oe[i] && pulse_db[i] == e8, "R8 nibble write data", pulse_db[i], e8);
            end
        end
        if (rd) last_rd = rv;
        check(rd_data == last_rd, rd ? "R9 read data" : "R9 rd_data kept on write", rd_data, last_rd);
        @(negedge clk);
        check(done == 1'b0, "R10 done one clock", int'(done), 0);
        check(req_ready == 1'b0, "R2 busy during recovery", int'(req_ready), 0);
        n = 0;
        while (!req_ready && n < 100) begin @(negedge clk); n++; end
        check(rd_data == last_rd, "R2 busy inputs ignored", rd_data, last_rd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(bus_e == 0 && bus_rw == 1 && db_oe == 0 && req_ready == 1 && done == 0 && rd_data == 0,
              "R1 reset state", {bus_e, bus_rw, db_oe, req_ready, done, rd_data},
              {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00});
        #1 rst_n = 1'b1;
        for (int nb = 0; nb < 2; nb++)
            for (int r = 0; r < 2; r++)
                for (int v = 0; v < 256; v++)
                    xfer(bit'(v[0] ^ nb[0]), bit'(r), bit'(nb), 8'(v), 8'(v * 37 + 11));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule